// File: doc/BRIEF.md
# Boundary-Scan Test Port with In-System Programming Commands

This block is a four-wire test access port controller (clock, mode select, serial in, serial out) that has no dedicated test-reset pin. It is returned to its reset state only by a power-up reset input, or by holding the mode-select input high for five clocks. It runs the standard sixteen-state test access port state machine and holds a 5-bit instruction register. A fixed opcode map combines boundary-scan test commands with the commands that erase, program and verify an on-chip nonvolatile array. Each instruction picks the data register that sits between serial in and serial out. The choices are a one-bit bypass cell, a 32-bit identifier, a boundary register, or a programming shift register that holds a row address and row data.

The nonvolatile array is outside the block. The block gives it the row address and data fields of the programming register. It also gives it three single-cycle strobes: erase, program and a read request used by verify. The read request returns a row into the register through the `ispRdData` input. Two flags go to the rest of the chip. One forces every system output into high impedance. The other marks that programming mode is active. A port-enable input hands the four pins to user logic when it is low. While it is low, the controller ignores its pins and keeps its state.

Top module: `jtag_isp_tap`

## Requirements
- R1: Mode select is sampled on the rising edge of the test clock and drives the standard sixteen-state sequence. Five clocks with mode select high reach Test-Logic-Reset from any state.
- R2: While `porRst` is high, the controller is held in Test-Logic-Reset. `tdoEn`, `highZ`, `ispMode` and all strobes are low.
- R3: Test-Logic-Reset makes the identifier instruction current. With that instruction, a data scan shifts out the 32-bit `ID_VALUE`, least significant bit first, and bit 0 is always 1.
- R4: Capture-IR loads 00001, which shifts out first-bit-first as 1,0,0,0,0. The current instruction changes only in Update-IR or Test-Logic-Reset.
- R5: `tdo` changes only on falling clock edges. `tdoEn` is high exactly during the falling-edge intervals that follow entry into Shift-IR or Shift-DR.
- R6: Opcode 11111, and every opcode not listed in these requirements, selects a one-bit bypass cell that captures 0. An N-bit scan therefore returns its input delayed by one bit, with a leading 0.
- R7: Opcode 00101 raises `highZ` while it is the current instruction and selects the bypass cell.
- R8: Opcodes 00000, 00010 and 00011 select the boundary register. Capture-DR loads `bsrIn`, and Update-DR copies the shifted value to `bsrOut`.
- R9: Opcode 01001 sets `ispMode` at Update-IR, and opcode 10000 clears it. Both select the programming register. Test-Logic-Reset also clears `ispMode`.
- R10: Opcodes 01010 (erase), 01011 (program) and 01100 (verify) act only while `ispMode` is set. Otherwise they select the bypass cell and raise no strobe.
- R11: With `ispMode` set, erase and program raise `ispEraseStb` or `ispProgStb` for the single Update-DR cycle. During that cycle `ispAddr` (upper `ADDR_W` bits of the register) and `ispData` (lower `DATA_W` bits) are valid. Verify raises `ispVerifyStb` in Capture-DR and loads `ispRdData` into the register.
- R12: While `portEn` is low, `tms` and `tdi` have no effect, the controller keeps its state, and `tdoEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| porRst | input | 1 | Power-up reset, active high, asynchronous |
| portEn | input | 1 | High: pins serve the test port; low: pins belong to user logic |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdoEn | output | 1 | Output driver enable for `tdo` |
| highZ | output | 1 | Force all system outputs to high impedance |
| ispMode | output | 1 | Programming mode active |
| bsrIn | input | BSR_LEN | Parallel values captured by the boundary register |
| bsrOut | output | BSR_LEN | Boundary register update stage |
| ispRdData | input | ADDR_W+DATA_W | Row read back for verify |
| ispAddr | output | ADDR_W | Row address field of the programming register |
| ispData | output | DATA_W | Row data field of the programming register |
| ispEraseStb | output | 1 | Erase strobe, one clock |
| ispProgStb | output | 1 | Program strobe, one clock |
| ispVerifyStb | output | 1 | Row read request, one clock |

## Verification
The program strobe and the address and data fields it qualifies are valid in the same Update-DR cycle. The bench shifts a known address and data word in, samples the fields at the falling edge where the strobe is high, and counts the strobe cycles. The verify read request and the capture of `ispRdData` also fall in one Capture-DR cycle; the value shifted out afterwards must equal the read-back word. A second coincidence is Test-Logic-Reset while high-impedance and programming mode are both active. Both flags are set first, and the bench then checks that one reset sequence clears them together and restores the identifier.

// File: rtl/tap_isp_pkg.sv
package tapIspPkg;
  localparam int IR_W = 5;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST  = 5'b00000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 5'b00001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 5'b00010;
  localparam logic [IR_W-1:0] OP_INTEST  = 5'b00011;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 5'b00101;
  localparam logic [IR_W-1:0] OP_ENABLE  = 5'b01001;
  localparam logic [IR_W-1:0] OP_ERASE   = 5'b01010;
  localparam logic [IR_W-1:0] OP_PROGRAM = 5'b01011;
  localparam logic [IR_W-1:0] OP_VERIFY  = 5'b01100;
  localparam logic [IR_W-1:0] OP_DISABLE = 5'b10000;
  localparam logic [IR_W-1:0] OP_BYPASS  = 5'b11111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_BSR, DR_ISP} drSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capDr;
    logic   shfDr;
    logic   updDr;
    logic   shfIr;
    logic   verifyLoad;
    drSel_e sel;
  } dpCtl_t;
endpackage

// File: rtl/tap_isp_ctrl.sv
module tap_isp_ctrl
  import tapIspPkg::*;
#(
  parameter bit HAS_IDCODE = 1'b1
) (
  input  logic            tck,
  input  logic            porRst,
  input  logic            portEn,
  input  logic            tms,
  input  logic            tdi,
  output tapState_e       tapState,
  output logic [IR_W-1:0] curIr,
  output logic            irLsb,
  output dpCtl_t          ctl,
  output logic            highZ,
  output logic            ispMode,
  output logic            ispEraseStb,
  output logic            ispProgStb,
  output logic            ispVerifyStb
);
  localparam logic [IR_W-1:0] RESET_OP = HAS_IDCODE ? OP_IDCODE : OP_BYPASS;

  tapState_e       nextState;
  logic [IR_W-1:0] irShift;
  drSel_e          drSel;
  logic            ispOp;

  always_comb begin
    nextState = tapState;
    case (tapState)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nextState = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nextState = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      default:   nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or posedge porRst) begin
    if (porRst) begin
      tapState <= ST_RESET;
      irShift  <= '0;
      curIr    <= RESET_OP;
      ispMode  <= 1'b0;
    end else if (portEn) begin
      tapState <= nextState;
      case (tapState)
        ST_RESET: begin
          curIr   <= RESET_OP;
          ispMode <= 1'b0;
        end
        ST_CAP_IR: irShift <= IR_CAPTURE;
        ST_SHF_IR: irShift <= {tdi, irShift[IR_W-1:1]};
        ST_UPD_IR: begin
          curIr <= irShift;
          if (irShift == OP_ENABLE)       ispMode <= 1'b1;
          else if (irShift == OP_DISABLE) ispMode <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // instruction decode: which data register sits on the scan path
  always_comb begin
    case (curIr)
      OP_IDCODE:                        drSel = HAS_IDCODE ? DR_IDCODE : DR_BYPASS;
      OP_EXTEST, OP_SAMPLE, OP_INTEST:  drSel = DR_BSR;
      OP_ENABLE, OP_DISABLE:            drSel = DR_ISP;
      OP_ERASE, OP_PROGRAM, OP_VERIFY:  drSel = ispMode ? DR_ISP : DR_BYPASS;
      default:                          drSel = DR_BYPASS;
    endcase
  end

  assign ispOp = ispMode && portEn;

  assign ctl.capDr      = portEn && (tapState == ST_CAP_DR);
  assign ctl.shfDr      = portEn && (tapState == ST_SHF_DR);
  assign ctl.updDr      = portEn && (tapState == ST_UPD_DR);
  assign ctl.shfIr      = portEn && (tapState == ST_SHF_IR);
  assign ctl.verifyLoad = ispOp && (curIr == OP_VERIFY);
  assign ctl.sel        = drSel;

  assign irLsb        = irShift[0];
  assign highZ        = (curIr == OP_HIGHZ);
  assign ispEraseStb  = ispOp && (curIr == OP_ERASE)   && (tapState == ST_UPD_DR);
  assign ispProgStb   = ispOp && (curIr == OP_PROGRAM) && (tapState == ST_UPD_DR);
  assign ispVerifyStb = ispOp && (curIr == OP_VERIFY)  && (tapState == ST_CAP_DR);
endmodule

// File: rtl/tap_isp_dp.sv
module tap_isp_dp
  import tapIspPkg::*;
#(
  parameter bit          HAS_IDCODE = 1'b1,
  parameter logic [31:0] ID_VALUE   = 32'h0B7E_40D5,
  parameter int          BSR_LEN    = 8,
  parameter int          ISP_LEN    = 16
) (
  input  logic               tck,
  input  logic               porRst,
  input  dpCtl_t             ctl,
  input  logic               irLsb,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] bsrIn,
  output logic [BSR_LEN-1:0] bsrOut,
  input  logic [ISP_LEN-1:0] ispRdData,
  output logic [ISP_LEN-1:0] ispSr,
  output logic               tdoQ,
  output logic               tdoEn
);
  logic               bypassBit;
  logic [BSR_LEN-1:0] bsrSr;
  logic               idLsb;
  logic               drLsb;

  generate
    if (HAS_IDCODE) begin : g_id
      logic [ID_W-1:0] idSr;
      always_ff @(posedge tck or posedge porRst) begin
        if (porRst)                                   idSr <= ID_VALUE;
        else if (ctl.capDr && ctl.sel == DR_IDCODE)   idSr <= ID_VALUE;
        else if (ctl.shfDr && ctl.sel == DR_IDCODE)   idSr <= {tdi, idSr[ID_W-1:1]};
      end
      assign idLsb = idSr[0];
    end else begin : g_noid
      assign idLsb = 1'b0;
    end
  endgenerate

  always_ff @(posedge tck or posedge porRst) begin
    if (porRst) begin
      bypassBit <= 1'b0;
      bsrSr     <= '0;
      bsrOut    <= '0;
      ispSr     <= '0;
    end else begin
      if (ctl.capDr) begin
        case (ctl.sel)
          DR_BYPASS: bypassBit <= 1'b0;
          DR_BSR:    bsrSr <= bsrIn;
          DR_ISP:    if (ctl.verifyLoad) ispSr <= ispRdData;
          default: ;
        endcase
      end else if (ctl.shfDr) begin
        case (ctl.sel)
          DR_BYPASS: bypassBit <= tdi;
          DR_BSR:    bsrSr <= {tdi, bsrSr[BSR_LEN-1:1]};
          DR_ISP:    ispSr <= {tdi, ispSr[ISP_LEN-1:1]};
          default: ;
        endcase
      end else if (ctl.updDr && ctl.sel == DR_BSR) begin
        bsrOut <= bsrSr;
      end
    end
  end

  always_comb begin
    case (ctl.sel)
      DR_IDCODE: drLsb = idLsb;
      DR_BSR:    drLsb = bsrSr[0];
      DR_ISP:    drLsb = ispSr[0];
      default:   drLsb = bypassBit;
    endcase
  end

  // serial output moves on the falling edge only
  always_ff @(negedge tck or posedge porRst) begin
    if (porRst) begin
      tdoQ  <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoQ  <= ctl.shfIr ? irLsb : drLsb;
      tdoEn <= ctl.shfIr || ctl.shfDr;
    end
  end
endmodule

// File: rtl/jtag_isp_tap.sv
module jtag_isp_tap
  import tapIspPkg::*;
#(
  parameter bit          HAS_IDCODE = 1'b1,
  parameter logic [31:0] ID_VALUE   = 32'h0B7E_40D5,
  parameter int          BSR_LEN    = 8,
  parameter int          ADDR_W     = 6,
  parameter int          DATA_W     = 10
) (
  input  logic                     tck,
  input  logic                     porRst,
  input  logic                     portEn,
  input  logic                     tms,
  input  logic                     tdi,
  output logic                     tdo,
  output logic                     tdoEn,
  output logic                     highZ,
  output logic                     ispMode,
  input  logic [BSR_LEN-1:0]       bsrIn,
  output logic [BSR_LEN-1:0]       bsrOut,
  input  logic [ADDR_W+DATA_W-1:0] ispRdData,
  output logic [ADDR_W-1:0]        ispAddr,
  output logic [DATA_W-1:0]        ispData,
  output logic                     ispEraseStb,
  output logic                     ispProgStb,
  output logic                     ispVerifyStb
);
  localparam int ISP_LEN = ADDR_W + DATA_W;

  tapState_e       tapState;
  logic [IR_W-1:0] curIr;
  logic            irLsb;
  dpCtl_t          ctl;
  logic [ISP_LEN-1:0] ispSr;

  tap_isp_ctrl #(.HAS_IDCODE(HAS_IDCODE)) u_ctrl (
    .tck(tck), .porRst(porRst), .portEn(portEn), .tms(tms), .tdi(tdi),
    .tapState(tapState), .curIr(curIr), .irLsb(irLsb), .ctl(ctl),
    .highZ(highZ), .ispMode(ispMode), .ispEraseStb(ispEraseStb),
    .ispProgStb(ispProgStb), .ispVerifyStb(ispVerifyStb)
  );

  tap_isp_dp #(
    .HAS_IDCODE(HAS_IDCODE), .ID_VALUE(ID_VALUE),
    .BSR_LEN(BSR_LEN), .ISP_LEN(ISP_LEN)
  ) u_dp (
    .tck(tck), .porRst(porRst), .ctl(ctl), .irLsb(irLsb), .tdi(tdi),
    .bsrIn(bsrIn), .bsrOut(bsrOut), .ispRdData(ispRdData), .ispSr(ispSr),
    .tdoQ(tdo), .tdoEn(tdoEn)
  );

  assign ispAddr = ispSr[ISP_LEN-1 -: ADDR_W];
  assign ispData = ispSr[DATA_W-1:0];
endmodule

// File: rtl/jtag_isp_tap_chk.sv
module jtag_isp_tap_chk
  import tapIspPkg::*;
(
  input logic            tck,
  input logic            porRst,
  input logic            portEn,
  input tapState_e       tapState,
  input logic [IR_W-1:0] curIr,
  input logic            tdoEn,
  input logic            ispMode,
  input logic            ispEraseStb,
  input logic            ispProgStb,
  input logic            ispVerifyStb
);
  // R4
  ir_update_only_chk: assert property (@(posedge tck) disable iff (porRst)
    !$stable(curIr) |-> ($past(tapState) == ST_UPD_IR || $past(tapState) == ST_RESET));

  // R5
  tdo_drive_shift_chk: assert property (@(posedge tck) disable iff (porRst)
    tdoEn |-> (tapState == ST_SHF_DR || tapState == ST_SHF_IR));

  // R10
  strobe_needs_isp_chk: assert property (@(posedge tck) disable iff (porRst)
    (ispEraseStb || ispProgStb || ispVerifyStb) |-> ispMode);

  // R11
  strobe_exclusive_chk: assert property (@(posedge tck) disable iff (porRst)
    $onehot0({ispEraseStb, ispProgStb, ispVerifyStb}));

  // R11
  prog_single_cycle_chk: assert property (@(posedge tck) disable iff (porRst)
    ispProgStb |=> !ispProgStb);

  // R12
  port_off_hold_chk: assert property (@(posedge tck) disable iff (porRst)
    !portEn |=> $stable(tapState));
endmodule

bind jtag_isp_tap jtag_isp_tap_chk u_chk (
  .tck(tck), .porRst(porRst), .portEn(portEn), .tapState(tapState),
  .curIr(curIr), .tdoEn(tdoEn), .ispMode(ispMode), .ispEraseStb(ispEraseStb),
  .ispProgStb(ispProgStb), .ispVerifyStb(ispVerifyStb)
);

// File: tb/jtag_isp_tap_bench.sv
`timescale 1ns/1ps
module jtag_isp_tap_bench;
  localparam logic [31:0] ID = 32'h0B7E_40D5;

  logic tck = 1'b0, porRst = 1'b1, portEn = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdoEn, highZ, ispMode;
  logic [7:0]  bsrIn = 8'h00, bsrOut;
  logic [15:0] ispRdData = 16'h0;
  logic [5:0]  ispAddr;
  logic [9:0]  ispData;
  logic ispEraseStb, ispProgStb, ispVerifyStb;

  int nTests = 0, nFail = 0;
  int eraseCnt = 0, progCnt = 0, verifyCnt = 0;
  logic [5:0] progAddrSeen;
  logic [9:0] progDataSeen;

  always #10 tck = ~tck;

  jtag_isp_tap u_jtag_isp_tap (
    .tck(tck), .porRst(porRst), .portEn(portEn), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdoEn(tdoEn), .highZ(highZ), .ispMode(ispMode),
    .bsrIn(bsrIn), .bsrOut(bsrOut), .ispRdData(ispRdData),
    .ispAddr(ispAddr), .ispData(ispData), .ispEraseStb(ispEraseStb),
    .ispProgStb(ispProgStb), .ispVerifyStb(ispVerifyStb)
  );

  always @(negedge tck) begin
    #1;
    if (ispEraseStb)  eraseCnt++;
    if (ispVerifyStb) verifyCnt++;
    if (ispProgStb) begin
      progCnt++;
      progAddrSeen = ispAddr;
      progDataSeen = ispData;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic tapReset();
    repeat (5) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic loadIr(input logic [4:0] op, output logic [4:0] capt);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) begin
      capt[i] = tdo;
      step(i == 4, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scanDr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge tck);
    #1;
    check(tdoEn == 0 && highZ == 0 && ispMode == 0, "R2 reset outputs",
          {tdoEn, highZ, ispMode}, 0);
    check(!ispEraseStb && !ispProgStb && !ispVerifyStb, "R2 strobes low",
          {ispEraseStb, ispProgStb, ispVerifyStb}, 0);
    porRst = 1'b0;
    step(0, 0);
  endtask

  task automatic t_idcode();
    logic [63:0] q;
    scanDr(32, 64'h0, q);
    check(q[31:0] == ID, "R3 identifier", q[31:0], ID);
    check(q[0] == 1'b1, "R3 bit0 is 1", q[0], 1);
  endtask

  task automatic t_tdoEdge();
    step(1, 0); step(0, 0); step(0, 0);
    check(tdoEn == 1 && tdo == ID[0], "R5 first bit", {tdoEn, tdo}, {1'b1, ID[0]});
    tms = 0; tdi = 0;
    @(posedge tck); #2;
    check(tdo == ID[0], "R5 held across rising edge", tdo, ID[0]);
    @(negedge tck); #1;
    check(tdo == ID[1], "R5 moves on falling edge", tdo, ID[1]);
    step(1, 0);
    check(tdoEn == 0, "R5 released after shift", tdoEn, 0);
    step(1, 0); step(0, 0);
  endtask

  task automatic t_irCapture();
    logic [4:0] c;
    loadIr(5'b11111, c);
    check(c == 5'b00001, "R4 capture pattern", c, 5'b00001);
  endtask

  task automatic t_bypass(input logic [4:0] op, input string tag);
    logic [63:0] q;
    logic [4:0] c;
    logic [7:0] d;
    d = 8'b1011_0111;
    loadIr(op, c);
    scanDr(8, {56'h0, d}, q);
    check(q[7:0] == {d[6:0], 1'b0}, tag, q[7:0], {d[6:0], 1'b0});
  endtask

  task automatic t_highz();
    logic [4:0] c;
    t_bypass(5'b00101, "R7 bypass path");
    check(highZ == 1, "R7 flag set", highZ, 1);
    loadIr(5'b11111, c);
    check(highZ == 0, "R7 flag cleared", highZ, 0);
  endtask

  task automatic t_bsr();
    logic [63:0] q;
    logic [4:0] c;
    bsrIn = 8'hA5;
    loadIr(5'b00010, c);
    scanDr(8, 64'h3C, q);
    check(q[7:0] == 8'hA5, "R8 sample capture", q[7:0], 8'hA5);
    check(bsrOut == 8'h3C, "R8 preload update", bsrOut, 8'h3C);
    bsrIn = 8'h5A;
    loadIr(5'b00000, c);
    scanDr(8, 64'hC3, q);
    check(q[7:0] == 8'h5A && bsrOut == 8'hC3, "R8 extest path", {q[7:0], bsrOut}, 16'h5AC3);
  endtask

  task automatic t_ispGate();
    check(ispMode == 0, "R10 mode off", ispMode, 0);
    t_bypass(5'b01010, "R10 erase gated to bypass");
    t_bypass(5'b01011, "R10 program gated to bypass");
    check(eraseCnt == 0 && progCnt == 0, "R10 no strobes", {eraseCnt[7:0], progCnt[7:0]}, 0);
  endtask

  task automatic t_ispFlow();
    logic [63:0] q;
    logic [4:0] c;
    loadIr(5'b01001, c);
    check(ispMode == 1, "R9 enable sets mode", ispMode, 1);
    loadIr(5'b01011, c);
    scanDr(16, 64'hABCD, q);
    check(progCnt == 1, "R11 one program strobe", progCnt, 1);
    check(progAddrSeen == 6'h2A && progDataSeen == 10'h3CD, "R11 address/data at strobe",
          {progAddrSeen, progDataSeen}, {6'h2A, 10'h3CD});
    loadIr(5'b01010, c);
    scanDr(16, 64'hABCD, q);
    check(eraseCnt == 1, "R11 one erase strobe", eraseCnt, 1);
    ispRdData = 16'h5E17;
    loadIr(5'b01100, c);
    scanDr(16, 64'h1234, q);
    check(q[15:0] == 16'h5E17 && verifyCnt == 1, "R11 verify read back",
          {verifyCnt[15:0], q[15:0]}, {16'd1, 16'h5E17});
    loadIr(5'b10000, c);
    check(ispMode == 0, "R9 disable clears mode", ispMode, 0);
    scanDr(16, 64'h0, q);
    check(q[15:0] == 16'h1234, "R9 disable keeps ISP register on path", q[15:0], 16'h1234);
  endtask

  task automatic t_tlr();
    logic [63:0] q;
    logic [4:0] c;
    loadIr(5'b01001, c);
    loadIr(5'b00101, c);
    check(highZ == 1 && ispMode == 1, "R1 flags before reset", {highZ, ispMode}, 2'b11);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    tapReset();
    check(highZ == 0 && ispMode == 0, "R1 R9 reset by mode select", {highZ, ispMode}, 0);
    scanDr(32, 64'h0, q);
    check(q[31:0] == ID, "R1 R3 identifier after reset", q[31:0], ID);
  endtask

  task automatic t_portEn();
    logic [63:0] q;
    logic [4:0] c;
    bit sawEn;
    loadIr(5'b11111, c);
    portEn = 0;
    sawEn = 0;
    step(1, 1); step(1, 0); step(0, 1); step(0, 0);
    for (int i = 0; i < 6; i++) begin
      if (tdoEn) sawEn = 1;
      step(i[0], 1);
    end
    check(!sawEn, "R12 output idle while pins released", sawEn, 0);
    portEn = 1;
    scanDr(8, 64'h96, q);
    check(q[7:0] == 8'h2C, "R12 state held, bypass still current", q[7:0], 8'h2C);
  endtask

  initial begin
    #(20 * 200000);
    nFail++; nTests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    t_reset();
    t_idcode();
    t_tdoEdge();
    t_irCapture();
    t_bypass(5'b11111, "R6 bypass delay");
    t_bypass(5'b00111, "R6 unknown opcode");
    t_highz();
    t_bsr();
    t_ispGate();
    t_ispFlow();
    t_tlr();
    t_portEn();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule